// File: doc/BRIEF.md
# Saturating Prescaled Charge Accumulator

This block turns a stream of charge quanta into a 16-bit accumulated-charge value. Each quantum is a single-cycle pulse with a direction bit: a high direction means charge flows in and a low one means it flows out. The pulses go into a signed residue counter. When the net count reaches plus or minus M, it emits one step to the accumulator, where M is a power of two chosen by a 3-bit select.

The accumulator clamps at both ends and never wraps. Any step that would carry it past a limit is dropped and raises a sticky range flag. Shutdown and undervoltage lockout both stop counting while the stored value is kept. Shutdown also discards the partial prescaler count, while lockout keeps it. A host write loads the accumulator, and a charge-complete request fills it. Both of these restart the residue from zero.

A pulse that is counted on a clock edge updates `acc_o` on that same edge.

Top module: `charge_accum`

## Requirements
- R1: After reset, `acc_o` is 16'h0000, `range_flag_o` is 0, the residue is zero and the registered select is 3'b111. So while `psel_i` stays at 3'b111, 128 pulses are needed per step.
- R2: M equals 2 to the power of `psel_i`. Each accepted pulse adds 1 to the signed residue when `dir_i`=1 and subtracts 1 when `dir_i`=0. When the residue reaches +M, `acc_o` rises by one. When it reaches -M, `acc_o` falls by one. In both cases the residue returns to zero.
- R3: `acc_o` stops at 16'hFFFF going up and at 16'h0000 going down. It stays there until a step in the other direction.
- R4: A step that is dropped at either limit sets `range_flag_o`. The flag stays set until `flag_clr_i` is pulsed. If a new dropped step and a clear happen in the same cycle, the flag remains set.
- R5: While `shdn_i` is high, pulses are ignored, `acc_o` holds its value and the residue is cleared.
- R6: While `uvlo_i` is high, pulses are ignored and both `acc_o` and the residue are kept. Counting then resumes from the kept residue.
- R7: `cc_req_i` forces `acc_o` to 16'hFFFF and clears the residue.
- R8: `wr_en_i` loads `wr_data_i` into the accumulator and clears the residue. A write takes priority over `cc_req_i`.
- R9: In a cycle where `psel_i` differs from the registered select, the residue clears and that cycle's pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | One charge quantum |
| dir_i | input | 1 | 1 = charge in, 0 = charge out |
| psel_i | input | 3 | Prescale exponent |
| shdn_i | input | 1 | Shutdown |
| uvlo_i | input | 1 | Undervoltage lockout |
| cc_req_i | input | 1 | Charge-complete fill request |
| wr_en_i | input | 1 | Host load strobe |
| wr_data_i | input | 16 | Host load value |
| flag_clr_i | input | 1 | Range flag clear strobe |
| acc_o | output | 16 | Accumulated charge |
| range_flag_o | output | 1 | Sticky over/underflow flag |

## Verification
The bench leaves a partial residue in place before each shutdown, lockout, write, fill and select change, then checks the exact pulse on which the next step arrives. A design that kept the residue through shutdown, or cleared it during lockout, steps one or more pulses too early or too late. Pushes past 16'hFFFF and 16'h0000 show whether a design wraps to the opposite end or misses the flag. A dropped step that coincides with a clear shows whether the clear wrongly wins. A write that coincides with a fill request shows whether the priority between them is reversed. The default select of 128 catches a design that resets the exponent to something other than seven.

// File: rtl/charge_accum_pkg.sv
package charge_accum_pkg;
    localparam int DEF_ACC_W = 16;
    localparam int DEF_SEL_W = 3;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_FILL,
        ACT_UP,
        ACT_DOWN
    } acc_act_e;
endpackage

// File: rtl/cq_prescale.sv
module cq_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             dir_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clear_i,
    input  logic             hold_i,
    output logic             step_up_o,
    output logic             step_dn_o
);
    localparam int MAX_EXP = (1 << SEL_W) - 1;
    localparam int RES_W   = MAX_EXP + 2;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [SEL_W-1:0] sel;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] inc;
    logic [RES_W-1:0] dec;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = sel_i;
        step_up_o = 1'b0;
        step_dn_o = 1'b0;
        mag       = RES_W'(1) << st_q.sel;
        inc       = st_q.res + RES_W'(1);
        dec       = st_q.res - RES_W'(1);
        if (clear_i || (sel_i != st_q.sel)) begin
            st_d.res = '0;
        end else if (pulse_i && !hold_i) begin
            if (dir_i) begin
                if (inc == mag) begin
                    st_d.res  = '0;
                    step_up_o = 1'b1;
                end else begin
                    st_d.res = inc;
                end
            end else begin
                if (dec == (RES_W'(0) - mag)) begin
                    st_d.res  = '0;
                    step_dn_o = 1'b1;
                end else begin
                    st_d.res = dec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.sel <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cq_accum.sv
module cq_accum
    import charge_accum_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up_i,
    input  logic             step_dn_i,
    input  logic             load_i,
    input  logic [ACC_W-1:0] load_val_i,
    input  logic             fill_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             sat_o
);
    localparam logic [ACC_W-1:0] TOP = '1;
    localparam logic [ACC_W-1:0] BOT = '0;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t  st_d, st_q;
    acc_act_e act;

    always_comb begin
        if (load_i)         act = ACT_LOAD;
        else if (fill_i)    act = ACT_FILL;
        else if (step_up_i) act = ACT_UP;
        else if (step_dn_i) act = ACT_DOWN;
        else                act = ACT_HOLD;

        st_d  = st_q;
        sat_o = 1'b0;
        case (act)
            ACT_LOAD: st_d.acc = load_val_i;
            ACT_FILL: st_d.acc = TOP;
            ACT_UP: begin
                if (st_q.acc == TOP) sat_o = 1'b1;
                else                 st_d.acc = st_q.acc + ACC_W'(1);
            end
            ACT_DOWN: begin
                if (st_q.acc == BOT) sat_o = 1'b1;
                else                 st_d.acc = st_q.acc - ACC_W'(1);
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;
endmodule

// File: rtl/cq_range_flag.sv
module cq_range_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/charge_accum.sv
module charge_accum
    import charge_accum_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             dir_i,
    input  logic [SEL_W-1:0] psel_i,
    input  logic             shdn_i,
    input  logic             uvlo_i,
    input  logic             cc_req_i,
    input  logic             wr_en_i,
    input  logic [ACC_W-1:0] wr_data_i,
    input  logic             flag_clr_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             range_flag_o
);
    logic step_up, step_dn, sat_evt, res_clear;

    assign res_clear = shdn_i | wr_en_i | cc_req_i;

    cq_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (pulse_i),
        .dir_i     (dir_i),
        .sel_i     (psel_i),
        .clear_i   (res_clear),
        .hold_i    (uvlo_i),
        .step_up_o (step_up),
        .step_dn_o (step_dn)
    );

    cq_accum #(.ACC_W(ACC_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up_i  (step_up),
        .step_dn_i  (step_dn),
        .load_i     (wr_en_i),
        .load_val_i (wr_data_i),
        .fill_i     (cc_req_i),
        .acc_o      (acc_o),
        .sat_o      (sat_evt)
    );

    cq_range_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sat_evt),
        .clr_i  (flag_clr_i),
        .flag_o (range_flag_o)
    );
endmodule

// File: rtl/charge_accum_chk.sv
module charge_accum_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shdn_i,
    input logic             uvlo_i,
    input logic             cc_req_i,
    input logic             wr_en_i,
    input logic [ACC_W-1:0] wr_data_i,
    input logic             flag_clr_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             range_flag_o
);
    localparam logic [ACC_W-1:0] TOP = '1;

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == TOP && !wr_en_i) |=> acc_o != '0);

    assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == '0 && !wr_en_i && !cc_req_i) |=> acc_o != TOP);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (range_flag_o && !flag_clr_i) |=> range_flag_o);

    assert_shdn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_i && !wr_en_i && !cc_req_i) |=> $stable(acc_o));

    assert_uvlo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_i && !wr_en_i && !cc_req_i) |=> $stable(acc_o));

    assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_req_i && !wr_en_i) |=> acc_o == TOP);

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> acc_o == $past(wr_data_i));
endmodule

bind charge_accum charge_accum_chk #(.ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_i       (shdn_i),
    .uvlo_i       (uvlo_i),
    .cc_req_i     (cc_req_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .flag_clr_i   (flag_clr_i),
    .acc_o        (acc_o),
    .range_flag_o (range_flag_o)
);

// File: tb/charge_accum_tb.sv
`timescale 1ns/1ps
module charge_accum_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_i = 1'b0;
    logic        dir_i = 1'b0;
    logic [2:0]  psel_i = 3'd7;
    logic        shdn_i = 1'b0;
    logic        uvlo_i = 1'b0;
    logic        cc_req_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] acc_o;
    logic        range_flag_o;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    charge_accum u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .dir_i(dir_i),
        .psel_i(psel_i), .shdn_i(shdn_i), .uvlo_i(uvlo_i), .cc_req_i(cc_req_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
        .acc_o(acc_o), .range_flag_o(range_flag_o)
    );

    // {req, pulse+dir, psel, shdn+uvlo+cc+wr, wdata, clr, exp_acc, exp_flag}
    localparam int NV = 51;
    localparam logic [46:0] VEC [NV] = '{
        {4'd9, 2'b11, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9 select change drops pulse
        {4'd2, 2'b11, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0001, 1'b0}, // R2 M=1
        {4'd2, 2'b11, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0002, 1'b0},
        {4'd2, 2'b10, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0001, 1'b0},
        {4'd2, 2'b10, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {4'd3, 2'b10, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R3 R4 underflow
        {4'd4, 2'b00, 3'd0, 4'b0000, 16'h0000, 1'b1, 16'h0000, 1'b0}, // R4 clear
        {4'd8, 2'b00, 3'd0, 4'b0001, 16'hFFFE, 1'b0, 16'hFFFE, 1'b0}, // R8 load
        {4'd3, 2'b11, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'd4, 2'b11, 3'd0, 4'b0000, 16'h0000, 1'b1, 16'hFFFF, 1'b1}, // R4 set beats clear
        {4'd3, 2'b10, 3'd0, 4'b0000, 16'h0000, 1'b0, 16'hFFFE, 1'b1}, // R3 reverses
        {4'd4, 2'b00, 3'd0, 4'b0000, 16'h0000, 1'b1, 16'hFFFE, 1'b0},
        {4'd5, 2'b11, 3'd0, 4'b1000, 16'h0000, 1'b0, 16'hFFFE, 1'b0}, // R5 shutdown
        {4'd6, 2'b11, 3'd0, 4'b0100, 16'h0000, 1'b0, 16'hFFFE, 1'b0}, // R6 lockout
        {4'd7, 2'b00, 3'd0, 4'b0010, 16'h0000, 1'b0, 16'hFFFF, 1'b0}, // R7 fill
        {4'd8, 2'b00, 3'd0, 4'b0011, 16'h0010, 1'b0, 16'h0010, 1'b0}, // R8 write beats fill
        {4'd9, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0010, 1'b0}, // R9 M=4
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0010, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0010, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0010, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0011, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0011, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0011, 1'b0},
        {4'd2, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0011, 1'b0},
        {4'd6, 2'b11, 3'd2, 4'b0100, 16'h0000, 1'b0, 16'h0011, 1'b0}, // R6 keeps residue 3
        {4'd6, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b00, 3'd2, 4'b1000, 16'h0000, 1'b0, 16'h0012, 1'b0}, // R5 drops residue 2
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd5, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0013, 1'b0},
        {4'd2, 2'b10, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0013, 1'b0},
        {4'd2, 2'b10, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0013, 1'b0},
        {4'd2, 2'b10, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0013, 1'b0},
        {4'd2, 2'b10, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0}, // R2 -M step
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0012, 1'b0},
        {4'd8, 2'b00, 3'd2, 4'b0001, 16'h0100, 1'b0, 16'h0100, 1'b0}, // R8 drops residue
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0100, 1'b0},
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0100, 1'b0},
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0100, 1'b0},
        {4'd8, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0101, 1'b0},
        {4'd7, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0101, 1'b0},
        {4'd7, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'h0101, 1'b0},
        {4'd7, 2'b00, 3'd2, 4'b0010, 16'h0000, 1'b0, 16'hFFFF, 1'b0}, // R7 drops residue
        {4'd7, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'd7, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'd7, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0},
        {4'd3, 2'b11, 3'd2, 4'b0000, 16'h0000, 1'b0, 16'hFFFF, 1'b1}  // R3 R4 overflow
    };

    task automatic check(input string req, input logic [15:0] acc_exp, input logic flag_exp);
        total++;
        if (acc_o !== acc_exp || range_flag_o !== flag_exp) begin
            bad++;
            $display("FAIL %s: acc=%h flag=%b expected acc=%h flag=%b",
                     req, acc_o, range_flag_o, acc_exp, flag_exp);
        end
    endtask

    task automatic pulse_up(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pulse_i = 1'b1;
            dir_i   = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        pulse_i = 1'b0;
    endtask

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VEC[i];
            @(negedge clk);
            {pulse_i, dir_i}                       = v[42:41];
            psel_i                                 = v[40:38];
            {shdn_i, uvlo_i, cc_req_i, wr_en_i}    = v[37:34];
            wr_data_i                              = v[33:18];
            flag_clr_i                             = v[17];
            @(posedge clk);
            #1;
            total++;
            if (acc_o !== v[16:1] || range_flag_o !== v[0]) begin
                bad++;
                $display("FAIL R%0d vector %0d: acc=%h flag=%b expected acc=%h flag=%b",
                         v[46:43], i, acc_o, range_flag_o, v[16:1], v[0]);
            end
        end

        // R1: reset again, select held at 3'b111 gives M=128
        @(negedge clk);
        {pulse_i, dir_i, shdn_i, uvlo_i, cc_req_i, wr_en_i, flag_clr_i} = '0;
        psel_i = 3'd7;
        rst_n  = 1'b0;
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;
        pulse_up(127);
        check("R1", 16'h0000, 1'b0);
        pulse_up(1);
        check("R1", 16'h0001, 1'b0);

        // R2: M=2 with a fresh select
        @(negedge clk);
        psel_i = 3'd1;
        @(posedge clk);
        pulse_up(1);
        check("R2", 16'h0001, 1'b0);
        pulse_up(1);
        check("R2", 16'h0002, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule